// File: doc/BRIEF.md
# Selectable Card Clock Generator

This block makes the clock for a smart-card contact from the chip's clock. It runs on a clock at twice the crystal rate, so one cycle of `clk_i` is half a crystal period. The card clock is the crystal rate divided by 8, 4, 2 or 1, chosen by a two-bit rate select. Because the output is a register toggled in the `clk_i` domain, even the undivided rate is a clean square wave.

A halt request freezes the card clock at a programmable level, high or low. Lifting the request lets the clock run again. The output moves only at phase boundaries, so neither the halt nor a rate change produces a shortened high or low phase.

Each card clock rising edge comes with a one-cycle marker pulse. Downstream cycle counters, such as an answer-window timer, count these pulses.

Top module: `card_clk_gen`

## Requirements
- R1: During reset and just after it, `card_clk_o` is 0 and `card_rise_o` is 0. The first low phase lasts 8 `clk_i` cycles, which is the /8 rate.
- R2: The half-period of the card clock in `clk_i` cycles depends on `rate_sel_i` (bit 1, bit 0) as follows: 00 gives 8, 01 gives 4, 11 gives 2 and 10 gives 1. The full periods are therefore crystal/8, /4, /2 and /1.
- R3: While no halt is involved, every phase lasts 1, 2, 4 or 8 cycles, and each high phase is as long as the low phase just before it. A rate change only affects phases that start with a falling edge.
- R4: Suppose `halt_i` is 1. Within two card periods, `card_clk_o` settles at the level given by `halt_high_i` (1 means high) and stays there, with no `card_rise_o` pulses.
- R5: When `halt_i` returns to 0 while the clock is held, `card_clk_o` changes on the first `clk_i` edge after that.
- R6: If `halt_high_i` is flipped while the clock is held, `card_clk_o` moves to the new level on the next edge and then holds there.
- R7: `card_rise_o` is 1 for exactly the cycles in which `card_clk_o` has just gone from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock at twice the crystal rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 2 | Divider select (encoding in R2) |
| halt_i | input | 1 | Request to freeze the card clock |
| halt_high_i | input | 1 | Frozen level: 1 high, 0 low |
| card_clk_o | output | 1 | Card clock |
| card_rise_o | output | 1 | One-cycle marker of each card clock rising edge |

## Verification
Both outputs are registers.

- A release of halt or a flip of the halt level while the clock is held shows on the first rising edge. The bench checks it at the falling edge right after it drives the change.
- After reset, the first rise is due 8 cycles after release.
- A rate change shows once the next phase that starts with a falling edge has begun. The bench therefore waits 40 cycles after each change before it measures phase lengths.
- A monitor samples at every falling edge. It measures each completed phase in whole cycles and compares the rise marker with the change seen in the same sample.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

   // Rate select codes; adjacent rates differ in one bit.
   typedef enum logic [1:0] {
      RATE_DIV8 = 2'b00,
      RATE_DIV4 = 2'b01,
      RATE_DIV1 = 2'b10,
      RATE_DIV2 = 2'b11
   } rate_e;

endpackage

// File: rtl/ccd_rate_decode.sv
module ccd_rate_decode
   import ccd_pkg::*;
#(
   parameter int SLOW_HALF = 8,
   parameter int CW        = $clog2(SLOW_HALF)
) (
   input  logic [1:0]    rate_sel_i,
   output logic [CW-1:0] half_m1_o
);

   localparam logic [CW-1:0] LEN_D8 = CW'(SLOW_HALF - 1);
   localparam logic [CW-1:0] LEN_D4 = CW'(SLOW_HALF / 2 - 1);
   localparam logic [CW-1:0] LEN_D2 = CW'(SLOW_HALF / 4 - 1);
   localparam logic [CW-1:0] LEN_D1 = '0;

   generate
      if (SLOW_HALF < 4 || (SLOW_HALF & (SLOW_HALF - 1)) != 0) begin : g_bad_half
         $error("SLOW_HALF must be a power of two, at least 4");
      end
      if (CW != $clog2(SLOW_HALF)) begin : g_bad_cw
         $error("CW must equal clog2(SLOW_HALF)");
      end
   endgenerate

   always_comb begin
      unique case (rate_sel_i)
         RATE_DIV8: half_m1_o = LEN_D8;
         RATE_DIV4: half_m1_o = LEN_D4;
         RATE_DIV2: half_m1_o = LEN_D2;
         default:   half_m1_o = LEN_D1;
      endcase
   end

endmodule

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen #(
   parameter int SLOW_HALF = 8,
   parameter int CW        = $clog2(SLOW_HALF)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] half_m1_i,
   input  logic          halt_i,
   input  logic          halt_high_i,
   output logic          clk_o,
   output logic          rise_o
);

   localparam logic [CW-1:0] RST_LEN = CW'(SLOW_HALF - 1);

   logic          out_q;
   logic          rise_q;
   logic [CW-1:0] rem_q;     // cycles left in the current phase, minus one
   logic [CW-1:0] hi_len_q;  // length chosen at the last falling edge
   logic          at_end;
   logic          hold;
   logic          toggle;

   assign at_end = (rem_q == '0);
   assign hold   = at_end && halt_i && (out_q == halt_high_i);
   assign toggle = at_end && !hold;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q    <= 1'b0;
         rise_q   <= 1'b0;
         rem_q    <= RST_LEN;
         hi_len_q <= RST_LEN;
      end else begin
         rise_q <= toggle && !out_q;
         if (toggle) begin
            out_q <= !out_q;
            if (out_q) begin
               // falling edge: sample the select for this low and next high
               rem_q    <= half_m1_i;
               hi_len_q <= half_m1_i;
            end else begin
               rem_q <= hi_len_q;
            end
         end else if (!at_end) begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   assign clk_o  = out_q;
   assign rise_o = rise_q;

   // R3: output only moves when the phase counter has run out
   p_phase_whole_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rem_q != '0) |=> $stable(out_q));

   // R4: a held clock at the requested level stays put
   p_halt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_i && out_q == halt_high_i && rem_q == '0) |=> $stable(out_q));

   // R5: leaving halt at a phase end moves the output on the next edge
   p_resume_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!halt_i && rem_q == '0) |=> !$stable(out_q));

   // R7: marker accompanies every rise and nothing else
   p_rise_mark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(out_q) |-> rise_q);

   p_rise_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_q |-> $rose(out_q));

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
   parameter int SLOW_HALF = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] rate_sel_i,
   input  logic       halt_i,
   input  logic       halt_high_i,
   output logic       card_clk_o,
   output logic       card_rise_o
);

   localparam int CW = $clog2(SLOW_HALF);

   logic [CW-1:0] half_m1;

   ccd_rate_decode #(
      .SLOW_HALF (SLOW_HALF),
      .CW        (CW)
   ) u_decode (
      .rate_sel_i (rate_sel_i),
      .half_m1_o  (half_m1)
   );

   ccd_phase_gen #(
      .SLOW_HALF (SLOW_HALF),
      .CW        (CW)
   ) u_phase (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .half_m1_i   (half_m1),
      .halt_i      (halt_i),
      .halt_high_i (halt_high_i),
      .clk_o       (card_clk_o),
      .rise_o      (card_rise_o)
   );

   // R1: no marker while the output is low
   p_rise_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      card_rise_o |-> card_clk_o);

endmodule

// File: tb/card_clk_gen_bench.sv
module card_clk_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] sel;
   logic       halt;
   logic       lvl;
   logic       card_clk;
   logic       card_rise;

   int  errs   = 0;
   int  checks = 0;
   bit  relax  = 1'b1;
   bit  armed  = 1'b0;
   bit  have_low = 1'b0;
   int  run    = 0;
   int  last_low = 0;
   logic prev = 1'b0;

   always #10 clk = !clk;

   card_clk_gen u_card_clk_gen (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .rate_sel_i  (sel),
      .halt_i      (halt),
      .halt_high_i (lvl),
      .card_clk_o  (card_clk),
      .card_rise_o (card_rise)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int half_of(input logic [1:0] s);
      case (s)
         2'b00:   return 8;
         2'b01:   return 4;
         2'b11:   return 2;
         default: return 1;
      endcase
   endfunction

   // Phase monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         run   = 0;
         armed = 1'b0;
         have_low = 1'b0;
      end else begin
         chk(card_rise == (card_clk && !prev), "R7 rise marker", int'(card_rise),
             int'(card_clk && !prev));
         if (card_clk != prev) begin
            if (armed && !relax) begin
               chk(run == 1 || run == 2 || run == 4 || run == 8, "R3 phase length", run, 8);
               if (prev && have_low)
                  chk(run == last_low, "R3 high equals low", run, last_low);
               if (!prev) begin
                  last_low = run;
                  have_low = 1'b1;
               end
            end else begin
               have_low = 1'b0;
            end
            armed = 1'b1;
            run   = 1;
         end else begin
            run++;
         end
      end
      prev = card_clk;
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_change(output int n);
      logic v;
      v = card_clk;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (card_clk == v && n < 1000);
   endtask

   initial begin
      int n;
      int h;
      rst_n = 1'b0;
      sel   = 2'b00;
      halt  = 1'b0;
      lvl   = 1'b0;
      cyc(5);
      chk(card_clk == 1'b0, "R1 reset clock low", int'(card_clk), 0);
      chk(card_rise == 1'b0, "R1 reset no marker", int'(card_rise), 0);
      rst_n = 1'b1;
      wait_change(n);
      chk(n == 8, "R1 first low phase", n, 8);
      relax = 1'b0;

      // R2 / R3: every ordered pair of rates
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            if (a != b) begin
               sel = 2'(a);
               cyc(20 + 3 * b);
               sel = 2'(b);
               cyc(40);
               h = half_of(2'(b));
               wait_change(n);
               wait_change(n);
               chk(n == h, "R2 half period", n, h);
               wait_change(n);
               chk(n == h, "R2 half period", n, h);
            end
         end
      end

      // R4 / R5 / R6: halt at each rate and level
      for (int s = 0; s < 4; s++) begin
         for (int l = 0; l < 2; l++) begin
            relax = 1'b1;
            sel = 2'(s);
            cyc(40);
            lvl  = l[0];
            halt = 1'b1;
            cyc(64);
            chk(card_clk == l[0], "R4 held level", int'(card_clk), l);
            n = 0;
            for (int i = 0; i < 20; i++) begin
               @(negedge clk);
               if (card_clk != l[0] || card_rise) n++;
            end
            chk(n == 0, "R4 stays held", n, 0);
            lvl = !l[0];
            @(negedge clk);
            chk(card_clk == !l[0], "R6 level flip moves", int'(card_clk), int'(!l[0]));
            n = 0;
            for (int i = 0; i < 30; i++) begin
               @(negedge clk);
               if (card_clk != !l[0]) n++;
            end
            chk(n == 0, "R6 holds new level", n, 0);
            halt = 1'b0;
            @(negedge clk);
            chk(card_clk == l[0], "R5 restart next edge", int'(card_clk), l);
            cyc(40);
            relax = 1'b0;
            cyc(40);
         end
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule